// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block lets a host processor hand a command, together with up to four 32-bit data words, to an embedded controller, and collect up to four result words once the controller finishes. The host sees a small set of 32-bit registers. It loads the outgoing data words and the two pointer registers, then writes one command word. That write packs the opcode, a sub-type, a payload length and an interrupt-on-completion flag. It also rings the controller's doorbell and marks the mailbox busy.

The controller sees the latched command fields, the pointer values and the outgoing data words. When it is done, it pulses a completion strobe carrying an error flag, an 8-bit error code and the result words. The host polls the status word until busy drops, checks the error bit, and reads the result words only when no error was reported. A host interrupt is raised on completion only for commands that asked for one. Commands written while the mailbox is busy are dropped and leave a sticky overrun mark.

Top module: `ipc_mbox_top`

## Requirements
- R1: After reset, busy, error, overrun, error code, command fields, doorbell and host interrupt are all zero. The status word (byte offset 0x04) then reads only the INITIATOR parameter in bits 15:8.
- R2: A host write to offset 0x00 while idle latches opcode = bits 7:0, ioc = bit 8, sub-type = bits 15:12 and length = bits 23:16 onto the controller outputs. The status bit 0 (busy) sets and status bits 7:4 show the sub-type. The doorbell is high for exactly the one cycle after the write.
- R3: Offset 0x00 reads as zero. Unmapped word offsets, and any address whose two low bits are not zero, read as zero and ignore writes.
- R4: A completion strobe while busy clears busy and loads status bit 1 (error) and bits 23:16 (error code) from the completion inputs. An accepted command clears error and code.
- R5: A completion without error copies the result words to read-buffer word i at offset 0x90+4i. A completion with error leaves the read buffer unchanged.
- R6: A command write while busy changes no command field and rings no doorbell. It sets status bit 2 (overrun), which stays set until reset.
- R7: The host interrupt is high for the one cycle after an accepted completion, and only if the command's ioc bit was set.
- R8: Write-buffer word i (offset 0x80+4i), source pointer (0x08) and destination pointer (0x0C) are readable by the host and driven to the controller. Host writes to them while busy are ignored.
- R9: A completion strobe while idle changes nothing.
- R10: The status word is read-only. Host writes to 0x04 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from the address |
| host_irq | output | 1 | Completion interrupt pulse to the host |
| ctl_doorbell | output | 1 | One-cycle command pulse to the controller |
| ctl_opcode | output | 8 | Latched opcode |
| ctl_ioc | output | 1 | Latched interrupt-on-completion flag |
| ctl_subtype | output | 4 | Latched sub-type |
| ctl_len | output | 8 | Latched payload length |
| ctl_src_ptr | output | 32 | Source pointer register |
| ctl_dst_ptr | output | 32 | Destination pointer register |
| ctl_wbuf | output | NWORDS*32 | Write-buffer words, word 0 in the low bits |
| ctl_done | input | 1 | Completion strobe from the controller |
| ctl_done_err | input | 1 | Error flag with the completion |
| ctl_done_code | input | 8 | Error code with the completion |
| ctl_done_data | input | NWORDS*32 | Result words, word 0 in the low bits |

## Verification
The bench builds the block with NWORDS = 4 and ADDR_W = 8, so that the full host map from 0x00 up to the last read-buffer word at 0x9C is decoded. INITIATOR is set to 0x5A, so the constant field of the status word is non-zero and visible against the busy, overrun, error and code bits. With these values a behavioural model can follow several cases cycle by cycle: back-to-back commands, overruns, completions while idle and error completions, and every status and buffer read can be predicted exactly.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int SUB_W    = 4;

    // word indices in the host map
    localparam int IDX_CMD  = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_SRC  = 2;
    localparam int IDX_DST  = 3;
    localparam int IDX_WBUF = 32;

    // command word field positions
    localparam int CMD_OP_LSB  = 0;
    localparam int CMD_IOC_BIT = 8;
    localparam int CMD_SUB_LSB = 12;
    localparam int CMD_LEN_LSB = 16;

    typedef struct packed {
        logic [BYTE_W-1:0] rsv_hi;
        logic [BYTE_W-1:0] code;
        logic [BYTE_W-1:0] initiator;
        logic [SUB_W-1:0]  sub;
        logic              rsv_lo;
        logic              ovr;
        logic              err;
        logic              busy;
    } stat_word_t;
endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
    import ipc_mbox_pkg::*;
#(
    parameter int NWORDS = 4,
    parameter int ADDR_W = 8
) (
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORD_W-1:0]             stat,
    input  logic [WORD_W-1:0]             sptr,
    input  logic [WORD_W-1:0]             dptr,
    input  logic [NWORDS-1:0][WORD_W-1:0] wbuf,
    input  logic [NWORDS-1:0][WORD_W-1:0] rbuf,
    output logic                          cmd_we,
    output logic                          sptr_we,
    output logic                          dptr_we,
    output logic [NWORDS-1:0]             wbuf_we,
    output logic [WORD_W-1:0]             rdata
);
    localparam int WIDX_W   = ADDR_W - 2;
    localparam int IDX_RBUF = IDX_WBUF + NWORDS;

    logic              aligned;
    logic [WIDX_W-1:0] widx;

    assign aligned = (addr[1:0] == 2'b00);
    assign widx    = addr[ADDR_W-1:2];

    assign cmd_we  = wr && aligned && (widx == WIDX_W'(IDX_CMD));
    assign sptr_we = wr && aligned && (widx == WIDX_W'(IDX_SRC));
    assign dptr_we = wr && aligned && (widx == WIDX_W'(IDX_DST));

    for (genvar i = 0; i < NWORDS; i++) begin : g_wbuf_we
        assign wbuf_we[i] = wr && aligned && (widx == WIDX_W'(IDX_WBUF + i));
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (widx == WIDX_W'(IDX_STAT)) rdata = stat;
            if (widx == WIDX_W'(IDX_SRC))  rdata = sptr;
            if (widx == WIDX_W'(IDX_DST))  rdata = dptr;
            for (int i = 0; i < NWORDS; i++) begin
                if (widx == WIDX_W'(IDX_WBUF + i)) rdata = wbuf[i];
                if (widx == WIDX_W'(IDX_RBUF + i)) rdata = rbuf[i];
            end
        end
    end
endmodule

// File: rtl/ipc_mbox_core.sv
module ipc_mbox_core
    import ipc_mbox_pkg::*;
#(
    parameter int                NWORDS    = 4,
    parameter logic [BYTE_W-1:0] INITIATOR = 8'h00
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_we,
    input  logic                          sptr_we,
    input  logic                          dptr_we,
    input  logic [NWORDS-1:0]             wbuf_we,
    input  logic [WORD_W-1:0]             wdata,
    input  logic                          done,
    input  logic                          done_err,
    input  logic [BYTE_W-1:0]             done_code,
    input  logic [NWORDS*WORD_W-1:0]      done_data,
    output logic [WORD_W-1:0]             stat,
    output logic [WORD_W-1:0]             sptr,
    output logic [WORD_W-1:0]             dptr,
    output logic [NWORDS-1:0][WORD_W-1:0] wbuf,
    output logic [NWORDS-1:0][WORD_W-1:0] rbuf,
    output logic                          bell,
    output logic                          irq,
    output logic [BYTE_W-1:0]             op,
    output logic                          ioc,
    output logic [SUB_W-1:0]              sub,
    output logic [BYTE_W-1:0]             len
);
    typedef struct packed {
        logic                          busy;
        logic                          err;
        logic                          ovr;
        logic                          ioc;
        logic                          bell;
        logic                          irq;
        logic [BYTE_W-1:0]             code;
        logic [BYTE_W-1:0]             op;
        logic [BYTE_W-1:0]             len;
        logic [SUB_W-1:0]              sub;
        logic [WORD_W-1:0]             sptr;
        logic [WORD_W-1:0]             dptr;
        logic [NWORDS-1:0][WORD_W-1:0] wbuf;
        logic [NWORDS-1:0][WORD_W-1:0] rbuf;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bell = 1'b0;
        st_d.irq  = 1'b0;
        if (cmd_we) begin
            if (st_q.busy) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.err  = 1'b0;
                st_d.code = '0;
                st_d.op   = wdata[CMD_OP_LSB +: BYTE_W];
                st_d.ioc  = wdata[CMD_IOC_BIT];
                st_d.sub  = wdata[CMD_SUB_LSB +: SUB_W];
                st_d.len  = wdata[CMD_LEN_LSB +: BYTE_W];
                st_d.bell = 1'b1;
            end
        end
        if (!st_q.busy) begin
            if (sptr_we) st_d.sptr = wdata;
            if (dptr_we) st_d.dptr = wdata;
            for (int i = 0; i < NWORDS; i++) begin
                if (wbuf_we[i]) st_d.wbuf[i] = wdata;
            end
        end
        if (done && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.err  = done_err;
            st_d.code = done_code;
            st_d.irq  = st_q.ioc;
            if (!done_err) st_d.rbuf = done_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    stat_word_t sw;
    assign sw = '{rsv_hi: '0, code: st_q.code, initiator: INITIATOR, sub: st_q.sub,
                  rsv_lo: 1'b0, ovr: st_q.ovr, err: st_q.err, busy: st_q.busy};

    assign stat = sw;
    assign sptr = st_q.sptr;
    assign dptr = st_q.dptr;
    assign wbuf = st_q.wbuf;
    assign rbuf = st_q.rbuf;
    assign bell = st_q.bell;
    assign irq  = st_q.irq;
    assign op   = st_q.op;
    assign ioc  = st_q.ioc;
    assign sub  = st_q.sub;
    assign len  = st_q.len;

    // R2
    bell_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bell |=> !st_q.bell);
    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(cmd_we));
    // R4
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.busy) |=> !st_q.busy);
    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |=> st_q.ovr);
    // R6
    busy_nobell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && st_q.busy) |=> (!st_q.bell && $stable(st_q.op)));
    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(done && st_q.busy && st_q.ioc));
endmodule

// File: rtl/ipc_mbox_top.sv
module ipc_mbox_top
    import ipc_mbox_pkg::*;
#(
    parameter int                NWORDS    = 4,
    parameter int                ADDR_W    = 8,
    parameter logic [BYTE_W-1:0] INITIATOR = 8'h00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [WORD_W-1:0]        host_wdata,
    output logic [WORD_W-1:0]        host_rdata,
    output logic                     host_irq,
    output logic                     ctl_doorbell,
    output logic [BYTE_W-1:0]        ctl_opcode,
    output logic                     ctl_ioc,
    output logic [SUB_W-1:0]         ctl_subtype,
    output logic [BYTE_W-1:0]        ctl_len,
    output logic [WORD_W-1:0]        ctl_src_ptr,
    output logic [WORD_W-1:0]        ctl_dst_ptr,
    output logic [NWORDS*WORD_W-1:0] ctl_wbuf,
    input  logic                     ctl_done,
    input  logic                     ctl_done_err,
    input  logic [BYTE_W-1:0]        ctl_done_code,
    input  logic [NWORDS*WORD_W-1:0] ctl_done_data
);
    logic                          cmd_we, sptr_we, dptr_we;
    logic [NWORDS-1:0]             wbuf_we;
    logic [WORD_W-1:0]             stat;
    logic [NWORDS-1:0][WORD_W-1:0] wbuf, rbuf;

    ipc_mbox_decode #(.NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_decode (
        .wr      (host_wr),
        .addr    (host_addr),
        .stat    (stat),
        .sptr    (ctl_src_ptr),
        .dptr    (ctl_dst_ptr),
        .wbuf    (wbuf),
        .rbuf    (rbuf),
        .cmd_we  (cmd_we),
        .sptr_we (sptr_we),
        .dptr_we (dptr_we),
        .wbuf_we (wbuf_we),
        .rdata   (host_rdata)
    );

    ipc_mbox_core #(.NWORDS(NWORDS), .INITIATOR(INITIATOR)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .sptr_we   (sptr_we),
        .dptr_we   (dptr_we),
        .wbuf_we   (wbuf_we),
        .wdata     (host_wdata),
        .done      (ctl_done),
        .done_err  (ctl_done_err),
        .done_code (ctl_done_code),
        .done_data (ctl_done_data),
        .stat      (stat),
        .sptr      (ctl_src_ptr),
        .dptr      (ctl_dst_ptr),
        .wbuf      (wbuf),
        .rbuf      (rbuf),
        .bell      (ctl_doorbell),
        .irq       (host_irq),
        .op        (ctl_opcode),
        .ioc       (ctl_ioc),
        .sub       (ctl_subtype),
        .len       (ctl_len)
    );

    assign ctl_wbuf = wbuf;
endmodule

// File: tb/ipc_mbox_top_tb.sv
module ipc_mbox_top_tb;
    localparam int NW = 4;
    localparam int AW = 8;
    localparam logic [7:0] INIT = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic host_irq, ctl_doorbell, ctl_ioc;
    logic [7:0] ctl_opcode, ctl_len;
    logic [3:0] ctl_subtype;
    logic [31:0] ctl_src_ptr, ctl_dst_ptr;
    logic [NW*32-1:0] ctl_wbuf;
    logic ctl_done = 1'b0;
    logic ctl_done_err = 1'b0;
    logic [7:0] ctl_done_code = '0;
    logic [NW*32-1:0] ctl_done_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ipc_mbox_top #(.NWORDS(NW), .ADDR_W(AW), .INITIATOR(INIT)) u_dut (.*);

    // behavioural reference model
    bit m_busy, m_err, m_ovr, m_ioc, m_bell, m_irq, ob;
    logic [7:0] m_code, m_op, m_len;
    logic [3:0] m_sub;
    logic [31:0] m_sptr, m_dptr;
    logic [31:0] m_wbuf [NW];
    logic [31:0] m_rbuf [NW];
    int widx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_ovr = 0; m_ioc = 0; m_bell = 0; m_irq = 0;
            m_code = 0; m_op = 0; m_len = 0; m_sub = 0; m_sptr = 0; m_dptr = 0;
            for (int i = 0; i < NW; i++) begin m_wbuf[i] = 0; m_rbuf[i] = 0; end
        end else begin
            ob = m_busy;
            m_bell = 0;
            m_irq = 0;
            widx = int'(host_addr) / 4;
            if (host_wr && host_addr[1:0] == 2'b00) begin
                if (widx == 0) begin
                    if (ob) m_ovr = 1;
                    else begin
                        m_busy = 1; m_err = 0; m_code = 0; m_bell = 1;
                        m_op = host_wdata[7:0]; m_ioc = host_wdata[8];
                        m_sub = host_wdata[15:12]; m_len = host_wdata[23:16];
                    end
                end else if (!ob) begin
                    if (widx == 2) m_sptr = host_wdata;
                    if (widx == 3) m_dptr = host_wdata;
                    if (widx >= 32 && widx < 32 + NW) m_wbuf[widx-32] = host_wdata;
                end
            end
            if (ctl_done && ob) begin
                m_busy = 0; m_err = ctl_done_err; m_code = ctl_done_code; m_irq = m_ioc;
                if (!ctl_done_err)
                    for (int i = 0; i < NW; i++) m_rbuf[i] = ctl_done_data[i*32 +: 32];
            end
        end
    end

    function automatic logic [31:0] mrd(input logic [AW-1:0] a);
        int w;
        w = int'(a) / 4;
        if (a[1:0] != 2'b00) return 32'h0;
        if (w == 1) return {8'h00, m_code, INIT, m_sub, 1'b0, m_ovr, m_err, m_busy};
        if (w == 2) return m_sptr;
        if (w == 3) return m_dptr;
        if (w >= 32 && w < 32 + NW) return m_wbuf[w-32];
        if (w >= 32 + NW && w < 32 + 2*NW) return m_rbuf[w-32-NW];
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // compare controller-side outputs against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 doorbell", 32'(ctl_doorbell), 32'(m_bell));
            check("R7 host_irq", 32'(host_irq), 32'(m_irq));
            check("R2 fields", {ctl_len, ctl_subtype, 3'b0, ctl_ioc, ctl_opcode, 8'h0},
                  {m_len, m_sub, 3'b0, m_ioc, m_op, 8'h0});
            check("R8 src_ptr", ctl_src_ptr, m_sptr);
            check("R8 dst_ptr", ctl_dst_ptr, m_dptr);
            for (int i = 0; i < NW; i++)
                check("R8 wbuf out", ctl_wbuf[i*32 +: 32], m_wbuf[i]);
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic finish_cmd(input bit e, input logic [7:0] c, input logic [NW*32-1:0] d);
        @(negedge clk);
        ctl_done = 1; ctl_done_err = e; ctl_done_code = c; ctl_done_data = d;
        @(negedge clk);
        ctl_done = 0;
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
        check({tag, " model"}, host_rdata, mrd(a));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd("R1 status", 8'h04, 32'h0000_5A00);
        check("R1 doorbell", 32'(ctl_doorbell), 32'h0);
        check("R1 irq", 32'(host_irq), 32'h0);
        rd("R1 rbuf0", 8'h90, 32'h0);

        // R8 data registers while idle
        for (int i = 0; i < NW; i++) wr(AW'(8'h80 + 4*i), 32'hA000_0000 + 32'(i));
        wr(8'h08, 32'h1234_5678);
        wr(8'h0C, 32'h9ABC_DEF0);
        for (int i = 0; i < NW; i++) rd("R8 wbuf readback", AW'(8'h80 + 4*i), 32'hA000_0000 + 32'(i));
        rd("R8 src", 8'h08, 32'h1234_5678);
        rd("R8 dst", 8'h0C, 32'h9ABC_DEF0);

        // R2 command accepted
        wr(8'h00, 32'h0002_31F4);
        check("R2 doorbell pulse", 32'(ctl_doorbell), 32'h1);
        check("R2 opcode", 32'(ctl_opcode), 32'hF4);
        check("R2 len", 32'(ctl_len), 32'h2);
        rd("R2 status busy", 8'h04, 32'h0000_5A31);
        @(negedge clk);
        check("R2 doorbell single", 32'(ctl_doorbell), 32'h0);

        // R3 command reads zero, reserved and misaligned
        rd("R3 cmd reads zero", 8'h00, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        rd("R3 reserved", 8'h40, 32'h0);
        rd("R3 misaligned", 8'h81, 32'h0);
        wr(8'h09, 32'h0BAD_0BAD);
        rd("R3 misaligned write", 8'h08, 32'h1234_5678);

        // R8 writes ignored while busy
        wr(8'h80, 32'hDEAD_BEEF);
        rd("R8 busy write ignored", 8'h80, 32'hA000_0000);

        // R6 overrun
        wr(8'h00, 32'h0000_10F0);
        check("R6 no doorbell", 32'(ctl_doorbell), 32'h0);
        check("R6 opcode kept", 32'(ctl_opcode), 32'hF4);
        rd("R6 status overrun", 8'h04, 32'h0000_5A35);

        // R4 R5 R7 successful completion
        finish_cmd(0, 8'h00, {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001});
        check("R7 irq pulse", 32'(host_irq), 32'h1);
        rd("R4 status done", 8'h04, 32'h0000_5A34);
        rd("R5 rbuf0", 8'h90, 32'h1111_0001);
        rd("R5 rbuf3", 8'h9C, 32'h4444_0004);

        // R9 completion while idle
        finish_cmd(0, 8'h11, {NW{32'hFFFF_FFFF}});
        check("R9 no irq", 32'(host_irq), 32'h0);
        rd("R9 status same", 8'h04, 32'h0000_5A34);
        rd("R9 rbuf same", 8'h94, 32'h2222_0002);

        // R4 R5 R7 error completion without ioc
        wr(8'h00, 32'h0000_00F1);
        rd("R4 error cleared", 8'h04, 32'h0000_5A05);
        finish_cmd(1, 8'h7E, {NW{32'h5555_5555}});
        check("R7 no irq without ioc", 32'(host_irq), 32'h0);
        rd("R4 status error", 8'h04, 32'h007E_5A06);
        rd("R5 rbuf kept on error", 8'h90, 32'h1111_0001);

        // R10 status is read-only
        wr(8'h04, 32'hFFFF_FFFF);
        rd("R10 status write ignored", 8'h04, 32'h007E_5A06);

        // R6 overrun clears only on reset
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        rd("R6 overrun reset", 8'h04, 32'h0000_5A00);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule